// File: doc/BRIEF.md
# Four-Rail Power Sequencing Controller

The block switches four regulator rail enables in a timed order from one global enable request. The request is the OR of an external pin and a software enable bit. A rising request starts a startup sequence. Rail 1 turns on at once, and rails 2, 3 and 4 each turn on after their own programmed delay. A falling request starts a shutdown sequence, in which every rail, rail 1 included, turns off after its own shutdown delay. Every delay is measured from the request edge itself. No delay is chained from the previous rail.

Each delay is a 5-bit code counted in units of a selectable step of 1 ms or 2 ms. Time comes from a millisecond prescaler on the system clock, and the prescaler restarts at every request edge. Each rail also has a direct enable. The direct enable is ORed into the rail's output, so a rail that is held on this way is not affected by sequence events. Software reads and writes the delay settings through a small byte-wide register bank. The reset values of the startup delays are build-time parameters, and all shutdown delays reset to zero.

Top module: `rail_seq`

## Requirements
- R1: After reset all rail outputs are 0. The startup codes and the step bit read back their parameter defaults, and every shutdown code reads back 0.
- R2: Rail 1 has no startup delay. Its output is 1 on the second clock edge after the request rises, counting the edge that samples the new request as the first.
- R3: A startup code N on rail 2, 3 or 4 makes that rail's output rise 2 + N*S*CYC_PER_MS edges after the request changes. S is 1 when the step bit is 0, and 2 when it is 1. Code 0 therefore gives 2 edges.
- R4: A shutdown code N on any rail makes that rail's output fall 2 + N*S*CYC_PER_MS edges after the request falls.
- R5: The request is the OR of en_pin_i and sw_en_i. Either input alone starts a sequence. A change on one input while the other is held at 1 causes no event.
- R6: Register map, with 8-bit addresses and data: 0x07 holds the step bit in [7] and the rail-2 startup code in [4:0]. 0x08 holds the rail-3 startup code and 0x09 the rail-4 startup code, each in [4:0]. The shutdown codes are at 0x0A for rail 1, 0x0B for rail 2, 0x0C for rail 4 and 0x0D for rail 3, each in [4:0].
- R7: Unused bits, which are [6:5] at 0x07 and [7:5] elsewhere, ignore writes and read as 0. Addresses outside 0x07..0x0D read as 0, and writes to them have no effect.
- R8: Each rail output is the registered OR of the sequenced state and rail_en_i for that rail. A rail held on by rail_en_i stays at 1 through startup and shutdown events.
- R9: If the request falls before a startup completes, the pending turn-ons are cancelled and shutdown timing starts from the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_pin_i | input | 1 | External sequence enable pin |
| sw_en_i | input | 1 | Software global enable bit |
| rail_en_i | input | 4 | Direct per-rail enables |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |
| rail_o | output | 4 | Registered rail enable outputs |

## Verification
The assertions check on every cycle the properties that hold locally. The tick is a single-cycle pulse. A rail's sequenced state holds between ticks while its delay is pending. Rail 1 follows a request rise. A direct enable forces its output, and a fall seen while a rail is off keeps it off. Register writes also land in the addressed field. Only the bench's scenarios can show the exact edge counts of each delay code under both step sizes, the register map with its reserved bits, the OR of the two enable sources, and the cancelling of an unfinished startup.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  localparam int NRAIL  = 4;
  localparam int CODE_W = 5;
  localparam int AW     = 8;
  localparam int DW     = 8;
  localparam int NREG   = 7;

  typedef logic [CODE_W-1:0] code_t;

  localparam logic [AW-1:0] A_UP2 = 8'h07;
  localparam logic [AW-1:0] A_UP3 = 8'h08;
  localparam logic [AW-1:0] A_UP4 = 8'h09;
  localparam logic [AW-1:0] A_DN1 = 8'h0A;
  localparam logic [AW-1:0] A_DN2 = 8'h0B;
  localparam logic [AW-1:0] A_DN4 = 8'h0C;
  localparam logic [AW-1:0] A_DN3 = 8'h0D;
endpackage

// File: rtl/rail_seq_tick.sv
module rail_seq_tick #(
  parameter int unsigned CYC_PER_MS = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [W-1:0] LAST = W'(CYC_PER_MS - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (CYC_PER_MS > 1) begin : g_chk
      p_tick_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/rail_seq_regs.sv
module rail_seq_regs
  import rail_seq_pkg::*;
#(
  parameter logic  DEF_STEP = 1'b0,
  parameter code_t DEF_UP2  = '0,
  parameter code_t DEF_UP3  = '0,
  parameter code_t DEF_UP4  = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  output logic                     step_o,
  output logic [NRAIL-1:0][CODE_W-1:0] up_o,
  output logic [NRAIL-1:0][CODE_W-1:0] dn_o
);
  logic [DW-1:0] reg_q [NREG];
  logic [2:0]    idx;
  logic          hit;

  // slot 0 keeps the step bit in [7]; all others keep only a code
  function automatic logic [DW-1:0] mask_of(input int i);
    return (i == 0) ? 8'h9F : 8'h1F;
  endfunction

  function automatic logic [DW-1:0] def_of(input int i);
    case (i)
      0:       return {DEF_STEP, 2'b00, DEF_UP2};
      1:       return {3'b000, DEF_UP3};
      2:       return {3'b000, DEF_UP4};
      default: return '0;
    endcase
  endfunction

  always_comb begin
    hit = 1'b1;
    idx = 3'd0;
    case (addr_i)
      A_UP2:   idx = 3'd0;
      A_UP3:   idx = 3'd1;
      A_UP4:   idx = 3'd2;
      A_DN1:   idx = 3'd3;
      A_DN2:   idx = 3'd4;
      A_DN4:   idx = 3'd5;
      A_DN3:   idx = 3'd6;
      default: hit = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            reg_q[g] <= def_of(g);
      else if (we_i && hit && idx == 3'(g))   reg_q[g] <= wdata_i & mask_of(g);
    end
  end

  assign rdata_o = hit ? reg_q[idx] : '0;

  assign step_o = reg_q[0][7];
  assign up_o[0] = '0;              // rail 1 has no startup delay
  assign up_o[1] = reg_q[0][CODE_W-1:0];
  assign up_o[2] = reg_q[1][CODE_W-1:0];
  assign up_o[3] = reg_q[2][CODE_W-1:0];
  assign dn_o[0] = reg_q[3][CODE_W-1:0];
  assign dn_o[1] = reg_q[4][CODE_W-1:0];
  assign dn_o[3] = reg_q[5][CODE_W-1:0];
  assign dn_o[2] = reg_q[6][CODE_W-1:0];

  p_wr_up3_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_UP3) |=> (up_o[2] == $past(wdata_i[CODE_W-1:0])));
endmodule

// File: rtl/rail_seq_timer.sv
module rail_seq_timer
  import rail_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rise_i,
  input  logic  fall_i,
  input  logic  tick_i,
  input  logic  step_i,
  input  code_t up_code_i,
  input  code_t dn_code_i,
  output logic  on_o
);
  localparam int TW = CODE_W + 1;

  logic [TW-1:0] tgt_c, tgt_q, cnt_q;
  logic          pend_q, dir_q, on_q;

  assign tgt_c = TW'(rise_i ? up_code_i : dn_code_i) << step_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      dir_q  <= 1'b0;
      on_q   <= 1'b0;
    end else if (rise_i || fall_i) begin
      // an edge always restarts timing, cancelling any pending change
      tgt_q <= tgt_c;
      cnt_q <= '0;
      dir_q <= rise_i;
      if (tgt_c == '0) begin
        on_q   <= rise_i;
        pend_q <= 1'b0;
      end else begin
        pend_q <= 1'b1;
      end
    end else if (pend_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q + 1'b1 == tgt_q) begin
        on_q   <= dir_q;
        pend_q <= 1'b0;
      end
    end
  end

  assign on_o = on_q;

  p_hold_between_ticks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !tick_i && !rise_i && !fall_i) |=> $stable(on_q));
  p_cancel_keeps_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !on_q) |=> !on_q);
endmodule

// File: rtl/rail_seq.sv
module rail_seq
  import rail_seq_pkg::*;
#(
  parameter int unsigned CYC_PER_MS = 125000,
  parameter logic        DEF_STEP   = 1'b0,
  parameter logic [4:0]  DEF_UP2    = 5'd0,
  parameter logic [4:0]  DEF_UP3    = 5'd0,
  parameter logic [4:0]  DEF_UP4    = 5'd0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_pin_i,
  input  logic       sw_en_i,
  input  logic [3:0] rail_en_i,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic [3:0] rail_o
);
  logic req, req_q, rise, fall, tick, step;
  logic [NRAIL-1:0][CODE_W-1:0] up_code, dn_code;
  logic [NRAIL-1:0] seq_on;
  logic [NRAIL-1:0] rail_q;

  assign req  = en_pin_i | sw_en_i;
  assign rise = req & ~req_q;
  assign fall = ~req & req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req;
  end

  rail_seq_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
    .clk_i, .rst_ni, .clr_i(rise | fall), .tick_o(tick)
  );

  rail_seq_regs #(
    .DEF_STEP(DEF_STEP), .DEF_UP2(DEF_UP2), .DEF_UP3(DEF_UP3), .DEF_UP4(DEF_UP4)
  ) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .step_o(step), .up_o(up_code), .dn_o(dn_code)
  );

  for (genvar r = 0; r < NRAIL; r++) begin : g_rail
    rail_seq_timer u_tmr (
      .clk_i, .rst_ni,
      .rise_i(rise), .fall_i(fall), .tick_i(tick), .step_i(step),
      .up_code_i(up_code[r]), .dn_code_i(dn_code[r]),
      .on_o(seq_on[r])
    );

    p_direct_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rail_en_i[r] |=> rail_q[r]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rail_q <= '0;
    else         rail_q <= seq_on | rail_en_i;
  end

  assign rail_o = rail_q;

  p_rail1_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |=> rail_q[0]);
endmodule

// File: tb/sim_rail_seq.sv
module sim_rail_seq;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_pin = 1'b0, sw_en = 1'b0, we = 1'b0;
  logic [3:0] rail_en = 4'h0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic [3:0] rail;

  int n_chk = 0, n_fail = 0;
  int tm[4];
  bit done = 0;

  always #4 clk = ~clk;

  rail_seq #(.CYC_PER_MS(P), .DEF_STEP(1'b0), .DEF_UP2(5'd3), .DEF_UP3(5'd6), .DEF_UP4(5'd9)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_pin_i(en_pin), .sw_en_i(sw_en),
    .rail_en_i(rail_en), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rail_o(rail)
  );

  // {step, up2, up3, up4, dn1, dn2, dn3, dn4}
  localparam logic [35:0] VEC [4] = '{
    {1'b0, 5'd10, 5'd20, 5'd30, 5'd0,  5'd0, 5'd0, 5'd0},
    {1'b1, 5'd1,  5'd0,  5'd31, 5'd3,  5'd0, 5'd7, 5'd31},
    {1'b0, 5'd31, 5'd1,  5'd2,  5'd31, 5'd2, 5'd1, 5'd0},
    {1'b1, 5'd0,  5'd5,  5'd5,  5'd0,  5'd0, 5'd0, 5'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    addr = a; #1;
    chk(rdata == exp, req, rdata, exp);
  endtask

  // edge index at which each rail first equals want, -1 if never
  task automatic measure(input logic want, input int ncyc);
    for (int r = 0; r < 4; r++) tm[r] = -1;
    for (int k = 1; k <= ncyc; k++) begin
      @(posedge clk); #1;
      for (int r = 0; r < 4; r++)
        if (tm[r] < 0 && rail[r] == want) tm[r] = k;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int mul;
    int cu[4];
    int cd[4];
    repeat (3) @(posedge clk); #1;
    rst_ni = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk(rail == 4'h0, "R1 rails off", rail, 0);
    rd_chk(8'h07, 8'h03, "R1 default 0x07");
    rd_chk(8'h09, 8'h09, "R1 default 0x09");
    rd_chk(8'h0D, 8'h00, "R1 default 0x0D");

    // R5 software enable alone starts, with default codes 3/6/9 at 1 ms
    sw_en = 1'b1;
    measure(1'b1, 60);
    chk(tm[0] == 2, "R2 rail1 on", tm[0], 2);
    chk(tm[1] == 2 + 3*P, "R5 sw start rail2", tm[1], 2 + 3*P);
    chk(tm[3] == 2 + 9*P, "R5 sw start rail4", tm[3], 2 + 9*P);
    en_pin = 1'b1;
    measure(1'b0, 20);
    sw_en = 1'b0;
    measure(1'b0, 20);
    chk(tm[0] < 0 && tm[1] < 0 && tm[2] < 0 && tm[3] < 0 && rail == 4'hF,
        "R5 no event while other held", rail, 15);
    en_pin = 1'b0;
    measure(1'b0, 10);
    chk(tm[0] == 2 && tm[3] == 2, "R4 zero shutdown", tm[3], 2);

    // R7 reserved bits and unmapped addresses
    wr(8'h08, 8'hFF);
    rd_chk(8'h08, 8'h1F, "R7 reserved 0x08");
    wr(8'h07, 8'h7F);
    rd_chk(8'h07, 8'h1F, "R7 reserved 0x07");
    wr(8'h20, 8'hAA);
    rd_chk(8'h20, 8'h00, "R7 unmapped");
    rd_chk(8'h0A, 8'h00, "R7 unmapped write no effect");

    // table walk: R3, R4, R6
    for (int v = 0; v < 4; v++) begin
      logic [35:0] e;
      e = VEC[v];
      mul = e[35] ? 2 : 1;
      cu[0] = 0; cu[1] = e[34:30]; cu[2] = e[29:25]; cu[3] = e[24:20];
      cd[0] = e[19:15]; cd[1] = e[14:10]; cd[2] = e[9:5]; cd[3] = e[4:0];
      wr(8'h07, {e[35], 2'b00, e[34:30]});
      wr(8'h08, {3'b000, e[29:25]});
      wr(8'h09, {3'b000, e[24:20]});
      wr(8'h0A, {3'b000, e[19:15]});
      wr(8'h0B, {3'b000, e[14:10]});
      wr(8'h0C, {3'b000, e[4:0]});
      wr(8'h0D, {3'b000, e[9:5]});
      rd_chk(8'h07, {e[35], 2'b00, e[34:30]}, "R6 readback 0x07");
      rd_chk(8'h0C, {3'b000, e[4:0]}, "R6 readback 0x0C rail4");
      rd_chk(8'h0D, {3'b000, e[9:5]}, "R6 readback 0x0D rail3");
      en_pin = 1'b1;
      measure(1'b1, 280);
      for (int r = 0; r < 4; r++)
        chk(tm[r] == 2 + cu[r]*mul*P, "R3 startup delay", tm[r], 2 + cu[r]*mul*P);
      en_pin = 1'b0;
      measure(1'b0, 280);
      for (int r = 0; r < 4; r++)
        chk(tm[r] == 2 + cd[r]*mul*P, "R4 shutdown delay", tm[r], 2 + cd[r]*mul*P);
    end

    // R8 direct enable overrides sequencing on rail 3
    rail_en = 4'b0100;
    @(posedge clk); @(posedge clk); #1;
    chk(rail == 4'b0100, "R8 direct on", rail, 4);
    begin
      int drops;
      drops = 0;
      en_pin = 1'b1;
      for (int k = 0; k < 150; k++) begin @(posedge clk); #1; if (!rail[2]) drops++; end
      en_pin = 1'b0;
      for (int k = 0; k < 150; k++) begin @(posedge clk); #1; if (!rail[2]) drops++; end
      chk(drops == 0, "R8 held through sequence", drops, 0);
    end
    rail_en = 4'b0000;
    @(posedge clk); @(posedge clk); #1;
    chk(rail == 4'b0000, "R8 release", rail, 0);

    // R9 cancel: rail4 at 20 ms, rail1 shutdown 5 ms, step 1 ms
    wr(8'h07, 8'h00);
    wr(8'h09, 8'd20);
    wr(8'h0A, 8'd5);
    en_pin = 1'b1;
    repeat (10) @(posedge clk); #1;
    en_pin = 1'b0;
    measure(1'b0, 30);
    chk(tm[0] == 2 + 5*P, "R9 shutdown from fall", tm[0], 2 + 5*P);
    measure(1'b1, 120);
    chk(tm[3] < 0, "R9 pending turn-on cancelled", tm[3], -1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule